// File: doc/BRIEF.md
# Power-Down Mode Sequencer with Wake Settle Timer

This block sequences a core between running, a light sleep and a deep standby, all under one 8-bit control register. When software raises a sleep request while the core is running, the upper register bit picks the target. A clear bit selects light sleep, where only the core clock is gated. A set bit selects deep standby, where the clock source is treated as stopped.

A wake interrupt in light sleep returns the core to running on the next cycle. A wake interrupt in deep standby starts a settle wait instead, so that the clock source can restabilise. The block holds the core clock gated for a programmable number of clock states, raises a one-cycle done strobe in the last of them, and then resumes running. A 3-bit field picks the wait from eight counts, and these counts do not rise monotonically with the code.

Top module: `pmc_top`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `mode` is 2'b00 (running), `clk_en` is 1 and `settle_done` is 0.
- R2: A register write stores bits 7:4 of `reg_wdata`. These bits read back on `reg_rdata[7:4]` from the cycle after the write. `reg_rdata[3:0]` always reads zero, whatever was written.
- R3: With bit 7 clear, a `sleep_req` seen in the running state puts `mode` to 2'b01 (light sleep) on the next cycle.
- R4: With bit 7 set, a `sleep_req` seen in the running state puts `mode` to 2'b10 (deep standby) on the next cycle.
- R5: `sleep_req` has no effect in any state other than running.
- R6: A `wake_irq` in light sleep returns `mode` to 2'b00 on the next cycle, with no settle wait.
- R7: A `wake_irq` in deep standby puts `mode` to 2'b11 (settling) for exactly N cycles, after which `mode` is 2'b00. N is set by bits 6:4 as follows: 000→8192, 001→16384, 010→32768, 011→65536, 100→131072, 101→1024, 110→128, 111→16.
- R8: `clk_en` is 0 whenever `mode` is not 2'b00.
- R9: `settle_done` is high for exactly one cycle per settle wait, and that cycle is the last one in which `mode` is 2'b11.
- R10: During a settle wait, register writes update `reg_rdata` but do not change the wait already under way. Further `wake_irq` pulses also have no effect on it.
- R11: Without a `wake_irq`, light sleep and deep standby are held indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_req | input | 1 | Sleep request |
| wake_irq | input | 1 | Wake-up interrupt |
| mode | output | 2 | 00 running, 01 light sleep, 10 deep standby, 11 settling |
| clk_en | output | 1 | Core clock enable |
| settle_done | output | 1 | One-cycle strobe at the end of a settle wait |

## Verification
If the settle counter is loaded from the wrong code, decremented at the wrong rate or disturbed by a write, the fault shows only as a wrong dwell time in `mode` 2'b11. That error is visible as soon as the wait ends, so every wait is timed cycle by cycle against a count the bench computes with its own formula. A state machine that mis-decodes bit 7 or accepts a request outside the running state shows up on `mode` and `clk_en` on the very next cycle, so those outputs are sampled after each stimulus.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int CNT_W = 18;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    PM_RUN     = 2'b00,
    PM_NAP     = 2'b01,
    PM_DEEP    = 2'b10,
    PM_SETTLE  = 2'b11
  } pm_state_e;

  // Settle length in clock states for each select code.
  function automatic logic [CNT_W-1:0] settle_states(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      3'd0:    n = CNT_W'(8192);
      3'd1:    n = CNT_W'(16384);
      3'd2:    n = CNT_W'(32768);
      3'd3:    n = CNT_W'(65536);
      3'd4:    n = CNT_W'(131072);
      3'd5:    n = CNT_W'(1024);
      3'd6:    n = CNT_W'(128);
      default: n = CNT_W'(16);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              deep_sel,
  output logic [SEL_W-1:0]  settle_sel,
  output logic [DATA_W-1:0] rdata
);
  localparam int LIVE_W = 1 + SEL_W;
  localparam int RSV_W  = DATA_W - LIVE_W;

  logic [LIVE_W-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  live_q <= '0;
    else if (we) live_q <= wdata[DATA_W-1 -: LIVE_W];
  end

  assign deep_sel   = live_q[LIVE_W-1];
  assign settle_sel = live_q[SEL_W-1:0];
  assign rdata      = {live_q, {RSV_W{1'b0}}};

  // R2
  always_comb begin
    if (rst_n) rsv_zero_chk: assert (rdata[RSV_W-1:0] == '0);
  end

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata[DATA_W-1 -: LIVE_W] == $past(wdata[DATA_W-1 -: LIVE_W]));

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (run && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == CNT_W'(1));

  // R10
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !expire) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R9
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      wake_irq,
  input  logic      deep_sel,
  input  logic      expire,
  output pm_state_e state,
  output logic      load_evt,
  output logic      settle_run
);
  pm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:    if (sleep_req) state_d = deep_sel ? PM_DEEP : PM_NAP;
      PM_NAP:    if (wake_irq)  state_d = PM_RUN;
      PM_DEEP:   if (wake_irq)  state_d = PM_SETTLE;
      PM_SETTLE: if (expire)    state_d = PM_RUN;
      default:                  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign load_evt   = (state_q == PM_DEEP) && wake_irq;
  assign settle_run = (state_q == PM_SETTLE);

  // R5
  nap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_NAP && !wake_irq) |=> state_q == PM_NAP);

  // R6
  nap_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_NAP && wake_irq) |=> state_q == PM_RUN);

  // R7
  deep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DEEP && wake_irq) |=> state_q == PM_SETTLE);

  // R9
  settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SETTLE && expire) |=> state_q == PM_RUN);

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sleep_req,
  input  logic       wake_irq,
  output logic [1:0] mode,
  output logic       clk_en,
  output logic       settle_done
);
  logic             deep_sel;
  logic [SEL_W-1:0] settle_sel;
  pm_state_e        state;
  logic             load_evt;
  logic             settle_run;
  logic             expire;

  pmc_ctrl_reg #(.DATA_W(8)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .wdata      (reg_wdata),
    .deep_sel   (deep_sel),
    .settle_sel (settle_sel),
    .rdata      (reg_rdata)
  );

  pmc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .wake_irq   (wake_irq),
    .deep_sel   (deep_sel),
    .expire     (expire),
    .state      (state),
    .load_evt   (load_evt),
    .settle_run (settle_run)
  );

  pmc_settle_timer u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_val (settle_states(settle_sel)),
    .run      (settle_run),
    .expire   (expire)
  );

  assign mode        = state;
  assign clk_en      = (state == PM_RUN);
  assign settle_done = expire;

  // R8
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |-> !clk_en);

  // R9
  done_in_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |-> mode == 2'b11);

endmodule

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sleep_req = 1'b0;
  logic       wake_irq = 1'b0;
  logic [1:0] mode;
  logic       clk_en;
  logic       settle_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pmc_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_req(sleep_req), .wake_irq(wake_irq),
    .mode(mode), .clk_en(clk_en), .settle_done(settle_done)
  );

  // write value, expected readback (R2)
  localparam logic [15:0] VEC [8] = '{
    {8'hFF, 8'hF0}, {8'h0F, 8'h00}, {8'hA5, 8'hA0}, {8'h5A, 8'h50},
    {8'h3C, 8'h30}, {8'hC3, 8'hC0}, {8'h81, 8'h80}, {8'h00, 8'h00}
  };

  function automatic int exp_len(input int sel);
    if (sel < 5) return 8192 << sel;
    return 8192 >> (3 * (sel - 4));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      check(1'b0, "watchdog", cyc, 190000);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
  endtask

  // Enter deep standby with select sel, wake, then time the settle wait.
  task automatic run_settle(input int sel, input bit disturb);
    int len = 0;
    int done_at = -1;
    int dones = 0;
    int cen_hi = 0;
    wr({1'b1, 3'(sel), 4'h0});
    pulse_sleep();
    check(mode == 2'b10, "R4 deep standby entry", mode, 2);
    check(clk_en == 1'b0, "R8 clk_en in standby", clk_en, 0);
    pulse_sleep();
    repeat (5) @(negedge clk);
    check(mode == 2'b10, "R5 R11 standby held", mode, 2);
    pulse_wake();
    while (mode == 2'b11 && len < 140000) begin
      if (clk_en) cen_hi++;
      if (settle_done) begin done_at = len; dones++; end
      if (disturb && len == 3) begin reg_we = 1'b1; reg_wdata = 8'h1F; wake_irq = 1'b1; end
      if (disturb && len == 4) begin reg_we = 1'b0; wake_irq = 1'b0; end
      len++;
      @(negedge clk);
    end
    check(len == exp_len(sel), disturb ? "R10 settle length kept" : "R7 settle length", len, exp_len(sel));
    check(mode == 2'b00, "R7 back to running", mode, 0);
    check(dones == 1 && done_at == exp_len(sel) - 1, "R9 done strobe", done_at, exp_len(sel) - 1);
    check(cen_hi == 0, "R8 clk_en low in settle", cen_hi, 0);
    if (disturb) check(reg_rdata == 8'h10, "R10 write in settle", reg_rdata, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    check(mode == 2'b00, "R1 mode", mode, 0);
    check(clk_en == 1'b1 && settle_done == 1'b0, "R1 outputs", clk_en, 1);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      wr(VEC[i][15:8]);
      check(reg_rdata == VEC[i][7:0], "R2 readback", reg_rdata, VEC[i][7:0]);
    end

    // light sleep
    wr(8'h70);
    pulse_sleep();
    check(mode == 2'b01, "R3 light sleep entry", mode, 1);
    check(clk_en == 1'b0, "R8 clk_en in sleep", clk_en, 0);
    wr(8'hF0);
    pulse_sleep();
    repeat (4) @(negedge clk);
    check(mode == 2'b01, "R5 R11 sleep held", mode, 1);
    pulse_wake();
    check(mode == 2'b00 && clk_en == 1'b1, "R6 wake from sleep", mode, 0);

    // deep standby waits, short to long
    run_settle(7, 1'b0);
    run_settle(6, 1'b0);
    run_settle(6, 1'b1);
    run_settle(5, 1'b0);
    run_settle(0, 1'b0);
    run_settle(1, 1'b0);
    run_settle(2, 1'b0);
    run_settle(3, 1'b0);

    finish_run();
  end
endmodule